// File: doc/BRIEF.md
# Flash Sector Protection and Security Gate

This block decides, request by request, whether a sectored flash array may be touched. Two requesters feed it. A debug/programming port can read, write and erase flash, load the protection registers and ask for debug access to the processor. An on-chip CPU bus can read and modify flash and read the protection registers. The gate holds a write-protect mask for the main array, a second mask for the secondary array, and a sticky security bit. Each accepted request leaves as exactly one of three things: a one-cycle grant toward the flash array, a one-cycle violation pulse, or a one-cycle register read response. The one exception is a register write, which produces no output.

The security bit is cleared in only one way. While it is set, the debug port is refused everything except a whole-device erase. CPU flash reads are never affected by it. The whole-device erase is a counted multi-cycle operation. For its whole length both requesters are stalled. When it ends, all protection state returns to zero in one step.

Both request inputs follow valid/ready rules. A request is taken on a rising edge where its valid and ready are both high. The requester must hold the request fields stable until that edge. Ready drops for the whole erase, and CPU ready also drops whenever the debug port is presenting a request. The grant, violation and response outputs have no back-pressure: each is a single-cycle pulse in the cycle that follows acceptance.

Top module: `flash_gate`

## Requirements
- R1: Register offset C0h holds the main mask. Bit i set to 1 makes main sector i (address bit 3 = 0, bits 2:0 = i) refuse writes (op 1) and sector erases (op 2) with a violation pulse and no grant. A clear bit lets them through as a grant.
- R2: Register offset C2h holds the secondary mask in bits 3:0 and the security bit in bit 7. Bits 6:4 always read back as 0. A mask bit set refuses writes and erases to secondary sector i (address bit 3 = 1). A secondary sector index at or above the secondary count, or a flash address with any of bits 7:4 set, is refused with a violation.
- R3: While the security bit is 1, every debug request except whole-device erase (op 5) gives a violation. This covers flash read (op 0), write, sector erase, register read (op 3), register write (op 4) and CPU debug access (op 6). None of these produces a grant or a response, and none changes any register.
- R4: An accepted whole-device erase gives a grant with op 5. From the next cycle, busy is high for exactly ERASE_CYCLES cycles, and both readies are low throughout. When busy falls, the main mask, the secondary mask and the security bit are all 0.
- R5: CPU flash reads (op 0) to a valid sector are granted whatever the security bit and the masks hold.
- R6: Register reads from either side return the register value, with 0 for any other offset. CPU register writes are ignored: they produce no output and the register contents do not change. This includes bit 7 at C2h.
- R7: por_n clears all registers and the security bit. rst_n clears only the output pulses and leaves the registers intact. After power-on reset, busy, grant, violation and response are all low and ready is high.
- R8: When both requesters are valid, the debug request is taken first and CPU ready is low in that cycle.
- R9: Every accepted request yields at most one of grant, violation or response, as a single-cycle pulse in the cycle after acceptance. A CPU whole-device erase and the reserved op 7 give a violation. A CPU debug access (op 6) also gives a violation. A debug access from the unsecured debug port is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears registers |
| rst_n | input | 1 | CPU-side reset, active low, clears output pulses only |
| dbg_valid | input | 1 | Debug request valid |
| dbg_ready | output | 1 | Debug request accepted on this edge when valid |
| dbg_op | input | 3 | Debug operation code |
| dbg_addr | input | 8 | Sector address or register offset |
| dbg_wdata | input | 8 | Register write data |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted on this edge when valid |
| cpu_op | input | 3 | CPU operation code |
| cpu_addr | input | 8 | Sector address or register offset |
| cpu_wdata | input | 8 | Register write data (ignored) |
| gnt_valid | output | 1 | One-cycle grant toward the flash array |
| gnt_src | output | 1 | Granted requester, 1 = debug port |
| gnt_op | output | 3 | Granted operation code |
| gnt_addr | output | 8 | Granted address |
| viol | output | 1 | One-cycle violation pulse |
| rsp_valid | output | 1 | One-cycle register read response |
| rsp_data | output | 8 | Register read data |
| busy | output | 1 | Whole-device erase in progress |
| secured | output | 1 | Current security bit |

## Verification
The bench builds the gate with 8 main sectors and 4 secondary sectors, so it can reach the out-of-range secondary indices 4 to 7 and the mask bits in both registers. It shortens ERASE_CYCLES to 5. With that value it can count the whole busy window, and it can show that both readies stay low until the registers clear. The bench also holds a CPU request pending while the debug port is presenting one, which exercises the ordering between the two requesters.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_SERASE = 3'd2,
    OP_RREAD  = 3'd3,
    OP_RWRITE = 3'd4,
    OP_CHIP   = 3'd5,
    OP_DEBUG  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef struct packed {
    logic       grant;
    logic       viol;
    logic       rsp;
    logic [7:0] rdata;
    logic       wr_main;
    logic       wr_sec;
    logic       start_erase;
  } verdict_t;
endpackage

// File: rtl/flash_gate_regs.sv
module flash_gate_regs #(
  parameter int N_MAIN = 8,
  parameter int N_SEC  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_main,
  input  logic              wr_sec,
  input  logic [7:0]        wdata,
  input  logic              clr,
  output logic [N_MAIN-1:0] main_prot,
  output logic [N_SEC-1:0]  sec_prot,
  output logic              secured
);
  // Nonvolatile in concept: only power-on reset or the erase clear them.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      main_prot <= '0;
      sec_prot  <= '0;
      secured   <= 1'b0;
    end else if (clr) begin
      main_prot <= '0;
      sec_prot  <= '0;
      secured   <= 1'b0;
    end else begin
      if (wr_main) main_prot <= wdata[N_MAIN-1:0];
      if (wr_sec) begin
        sec_prot <= wdata[N_SEC-1:0];
        secured  <= wdata[7];
      end
    end
  end

  // R6: security bit moves only on a permitted register write or the erase clear
  a_r6_sec_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!wr_sec && !clr) |=> $stable(secured));
  // R4: the erase clear leaves everything at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (main_prot == '0 && sec_prot == '0 && !secured));
endmodule

// File: rtl/flash_gate_policy.sv
module flash_gate_policy
  import flash_gate_pkg::*;
#(
  parameter int         N_MAIN   = 8,
  parameter int         N_SEC    = 4,
  parameter logic [7:0] MAIN_OFS = 8'hC0,
  parameter logic [7:0] SEC_OFS  = 8'hC2
) (
  input  logic              from_dbg,
  input  op_e               op,
  input  logic [7:0]        addr,
  input  logic              secured,
  input  logic [N_MAIN-1:0] main_prot,
  input  logic [N_SEC-1:0]  sec_prot,
  output verdict_t          v
);
  logic [7:0] main_pad, sec_pad;
  logic [2:0] idx;
  logic       in_sec, in_range, locked;

  always_comb begin
    main_pad = 8'(main_prot);
    sec_pad  = 8'(sec_prot);
    idx      = addr[2:0];
    in_sec   = addr[3];
    in_range = (addr[7:4] == 4'h0) &&
               (in_sec ? (int'(idx) < N_SEC) : (int'(idx) < N_MAIN));
    locked   = in_sec ? sec_pad[idx] : main_pad[idx];
  end

  always_comb begin
    v = '0;
    if (from_dbg && secured && op != OP_CHIP) begin
      v.viol = 1'b1;
    end else begin
      unique case (op)
        OP_READ:   begin v.grant = in_range; v.viol = !in_range; end
        OP_WRITE,
        OP_SERASE: begin
          v.grant = in_range && !locked;
          v.viol  = !(in_range && !locked);
        end
        OP_RREAD: begin
          v.rsp = 1'b1;
          if (addr == MAIN_OFS)     v.rdata = main_pad;
          else if (addr == SEC_OFS) v.rdata = {secured, 3'b000, sec_pad[3:0]};
          else                      v.rdata = 8'h00;
        end
        OP_RWRITE: begin
          v.wr_main = from_dbg && (addr == MAIN_OFS);
          v.wr_sec  = from_dbg && (addr == SEC_OFS);
        end
        OP_CHIP:   begin v.grant = from_dbg; v.start_erase = from_dbg; v.viol = !from_dbg; end
        OP_DEBUG:  begin v.grant = from_dbg; v.viol = !from_dbg; end
        default:   v.viol = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/flash_gate_eraser.sv
module flash_gate_eraser #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R4: no new erase may be launched while one runs
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!por_n)
    start |-> !busy);
endmodule

// File: rtl/flash_gate.sv
module flash_gate
  import flash_gate_pkg::*;
#(
  parameter int         N_MAIN       = 8,
  parameter int         N_SEC        = 4,
  parameter int         ERASE_CYCLES = 16,
  parameter logic [7:0] MAIN_OFS     = 8'hC0,
  parameter logic [7:0] SEC_OFS      = 8'hC2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       dbg_valid,
  output logic       dbg_ready,
  input  logic [2:0] dbg_op,
  input  logic [7:0] dbg_addr,
  input  logic [7:0] dbg_wdata,
  input  logic       cpu_valid,
  output logic       cpu_ready,
  input  logic [2:0] cpu_op,
  input  logic [7:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic       gnt_valid,
  output logic       gnt_src,
  output logic [2:0] gnt_op,
  output logic [7:0] gnt_addr,
  output logic       viol,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       busy,
  output logic       secured
);
  logic              sys_rst_n;
  logic              dbg_fire, cpu_fire, any_fire;
  op_e               sel_op;
  logic [7:0]        sel_addr, sel_wdata;
  logic [N_MAIN-1:0] main_prot;
  logic [N_SEC-1:0]  sec_prot;
  logic              erase_done;
  verdict_t          v;

  assign sys_rst_n = rst_n & por_n;

  // Debug side wins; everything stalls while the erase runs.
  assign dbg_ready = !busy;
  assign cpu_ready = !busy && !dbg_valid;
  assign dbg_fire  = dbg_valid && dbg_ready;
  assign cpu_fire  = cpu_valid && cpu_ready;
  assign any_fire  = dbg_fire || cpu_fire;

  // cpu_wdata enters the mux but no CPU write ever reaches the registers.
  always_comb begin
    sel_op    = op_e'(dbg_fire ? dbg_op : cpu_op);
    sel_addr  = dbg_fire ? dbg_addr : cpu_addr;
    sel_wdata = dbg_fire ? dbg_wdata : cpu_wdata;
  end

  flash_gate_policy #(
    .N_MAIN(N_MAIN), .N_SEC(N_SEC), .MAIN_OFS(MAIN_OFS), .SEC_OFS(SEC_OFS)
  ) policy_i (
    .from_dbg(dbg_fire), .op(sel_op), .addr(sel_addr), .secured(secured),
    .main_prot(main_prot), .sec_prot(sec_prot), .v(v)
  );

  flash_gate_regs #(.N_MAIN(N_MAIN), .N_SEC(N_SEC)) regs_i (
    .clk(clk), .por_n(por_n),
    .wr_main(any_fire && v.wr_main), .wr_sec(any_fire && v.wr_sec),
    .wdata(sel_wdata), .clr(erase_done),
    .main_prot(main_prot), .sec_prot(sec_prot), .secured(secured)
  );

  flash_gate_eraser #(.CYCLES(ERASE_CYCLES)) eraser_i (
    .clk(clk), .por_n(por_n), .start(any_fire && v.start_erase),
    .busy(busy), .done(erase_done)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      gnt_valid <= 1'b0;
      gnt_src   <= 1'b0;
      gnt_op    <= 3'd0;
      gnt_addr  <= 8'h00;
      viol      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      gnt_valid <= any_fire && v.grant;
      viol      <= any_fire && v.viol;
      rsp_valid <= any_fire && v.rsp;
      if (any_fire) begin
        gnt_src  <= dbg_fire;
        gnt_op   <= sel_op;
        gnt_addr <= sel_addr;
        rsp_data <= v.rdata;
      end
    end
  end

  // R3: a locked debug port gets only violations, except the whole-device erase
  a_r3_locked_debug: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (dbg_fire && secured && dbg_op != 3'd5) |=> (viol && !gnt_valid && !rsp_valid));
  // R4: nothing is accepted during the erase
  a_r4_stall: assert property (@(posedge clk) disable iff (!sys_rst_n)
    busy |-> (!dbg_ready && !cpu_ready));
  // R4: the end of busy leaves a blank, unsecured device
  a_r4_blank_after: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(busy) |-> (!secured && main_prot == '0 && sec_prot == '0));
  // R5: CPU reads of a valid sector always go through
  a_r5_cpu_read: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cpu_fire && cpu_op == 3'd0 && cpu_addr[7:4] == 4'h0 &&
     (!cpu_addr[3] || int'(cpu_addr[2:0]) < N_SEC)) |=> (gnt_valid && !gnt_src));
  // R2: unused bits of the secondary register read as zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (any_fire && sel_op == OP_RREAD && sel_addr == SEC_OFS) |=> (rsp_data[6:4] == 3'b000));
  // R8: debug request blocks the CPU in the same cycle
  a_r8_priority: assert property (@(posedge clk) disable iff (!sys_rst_n)
    dbg_valid |-> !cpu_ready);
  // R9: at most one kind of outcome per cycle
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $onehot0({gnt_valid, viol, rsp_valid}));
endmodule

// File: tb/flash_gate_tb_top.sv
module flash_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE = 5;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic dbg_valid = 1'b0, cpu_valid = 1'b0;
  logic dbg_ready, cpu_ready;
  logic [2:0] dbg_op = 3'd0, cpu_op = 3'd0;
  logic [7:0] dbg_addr = 8'h00, dbg_wdata = 8'h00, cpu_addr = 8'h00, cpu_wdata = 8'h00;
  logic gnt_valid, gnt_src, viol, rsp_valid, busy, secured;
  logic [2:0] gnt_op;
  logic [7:0] gnt_addr, rsp_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_gate #(.N_MAIN(8), .N_SEC(4), .ERASE_CYCLES(ERASE)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .dbg_valid(dbg_valid), .dbg_ready(dbg_ready), .dbg_op(dbg_op),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .gnt_valid(gnt_valid), .gnt_src(gnt_src), .gnt_op(gnt_op), .gnt_addr(gnt_addr),
    .viol(viol), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .secured(secured)
  );

  // Kinds: 0 grant, 1 violation, 2 response
  typedef struct {
    int       kind;
    bit       src;
    bit [2:0] op;
    bit [7:0] addr;
    bit [7:0] data;
    string    req;
  } exp_t;
  exp_t q[$];

  bit [7:0] m_main = 8'h00;
  bit [3:0] m_sec = 4'h0;
  bit       m_secured = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench model of the requirements; pushes the expected outcome.
  task automatic predict(input bit dbg, input bit [2:0] op, input bit [7:0] addr,
                         input bit [7:0] wd, input string req);
    exp_t e;
    bit ok, prot;
    ok   = (addr[7:4] == 0) && (!addr[3] || addr[2:0] < 4);
    prot = addr[3] ? m_sec[addr[1:0]] : m_main[addr[2:0]];
    e.src = dbg; e.op = op; e.addr = addr; e.data = 0; e.req = req; e.kind = -1;
    if (dbg && m_secured && op != 3'd5) e.kind = 1;
    else case (op)
      3'd0: e.kind = ok ? 0 : 1;
      3'd1, 3'd2: e.kind = (ok && !prot) ? 0 : 1;
      3'd3: begin
        e.kind = 2;
        e.data = (addr == 8'hC0) ? m_main : (addr == 8'hC2) ? {m_secured, 3'b000, m_sec} : 8'h00;
      end
      3'd4: if (dbg) begin
        if (addr == 8'hC0) m_main = wd;
        if (addr == 8'hC2) begin m_sec = wd[3:0]; m_secured = wd[7]; end
      end
      3'd5: begin
        e.kind = dbg ? 0 : 1;
        if (dbg) begin m_main = 0; m_sec = 0; m_secured = 0; end
      end
      3'd6: e.kind = dbg ? 0 : 1;
      default: e.kind = 1;
    endcase
    if (e.kind >= 0) q.push_back(e);
  endtask

  task automatic send(input bit dbg, input bit [2:0] op, input bit [7:0] addr,
                      input bit [7:0] wd, input string req);
    @(negedge clk);
    if (dbg) begin dbg_valid = 1; dbg_op = op; dbg_addr = addr; dbg_wdata = wd; end
    else     begin cpu_valid = 1; cpu_op = op; cpu_addr = addr; cpu_wdata = wd; end
    #1;
    while (!(dbg ? dbg_ready : cpu_ready)) begin @(negedge clk); #1; end
    predict(dbg, op, addr, wd, req);
    @(negedge clk);
    if (dbg) dbg_valid = 0; else cpu_valid = 0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (por_n && rst_n && (gnt_valid || viol || rsp_valid)) begin
      int kind;
      exp_t e;
      kind = gnt_valid ? 0 : viol ? 1 : 2;
      if (q.size() == 0) begin
        chk(0, "R9", "unexpected outcome kind", kind, -1);
      end else begin
        e = q.pop_front();
        chk(kind == e.kind, e.req, "outcome kind", kind, e.kind);
        if (kind == 0 && e.kind == 0) begin
          chk(gnt_src == e.src, e.req, "grant source", gnt_src, e.src);
          chk(gnt_op == e.op, e.req, "grant op", gnt_op, e.op);
          chk(gnt_addr == e.addr, e.req, "grant addr", gnt_addr, e.addr);
        end
        if (kind == 2 && e.kind == 2)
          chk(rsp_data == e.data, e.req, "read data", rsp_data, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1; rst_n = 1;
    @(negedge clk);
    chk(!busy && !gnt_valid && !viol && !rsp_valid, "R7", "outputs after reset", busy, 0);
    chk(dbg_ready && cpu_ready && !secured, "R7", "ready after reset", dbg_ready, 1);

    // Load masks from the debug port; bits 6:4 written as 1
    send(1, 3'd4, 8'hC0, 8'hA5, "R1");
    send(1, 3'd4, 8'hC2, 8'h7A, "R2");
    send(0, 3'd3, 8'hC0, 0, "R6");
    send(0, 3'd3, 8'hC2, 0, "R2");
    send(1, 3'd3, 8'hC4, 0, "R6");
    // CPU register writes are ignored
    send(0, 3'd4, 8'hC0, 8'hFF, "R6");
    send(0, 3'd4, 8'hC2, 8'h8F, "R6");
    send(0, 3'd3, 8'hC0, 0, "R6");
    send(0, 3'd3, 8'hC2, 0, "R6");
    chk(!secured, "R6", "cpu cannot set security", secured, 0);

    // Sector protection
    send(1, 3'd1, 8'h00, 0, "R1");
    send(1, 3'd1, 8'h01, 0, "R1");
    send(0, 3'd2, 8'h02, 0, "R1");
    send(0, 3'd2, 8'h03, 0, "R1");
    send(0, 3'd1, 8'h07, 0, "R1");
    send(1, 3'd1, 8'h09, 0, "R2");
    send(0, 3'd2, 8'h08, 0, "R2");
    send(0, 3'd0, 8'h0D, 0, "R2");
    send(1, 3'd1, 8'h1A, 0, "R2");
    send(0, 3'd0, 8'h00, 0, "R5");
    send(0, 3'd5, 8'h00, 0, "R9");
    send(0, 3'd6, 8'h00, 0, "R9");
    send(1, 3'd6, 8'h00, 0, "R9");
    send(1, 3'd7, 8'h00, 0, "R9");

    // Both requesters at once
    fork
      send(1, 3'd0, 8'h04, 0, "R8");
      send(0, 3'd0, 8'h05, 0, "R8");
      begin @(negedge clk); #2; chk(!cpu_ready, "R8", "cpu ready while debug valid", cpu_ready, 0); end
    join

    // CPU-side reset keeps the registers
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    send(0, 3'd3, 8'hC0, 0, "R7");

    // Secure the device
    send(1, 3'd4, 8'hC2, 8'h83, "R3");
    @(negedge clk);
    chk(secured, "R3", "secured flag", secured, 1);
    send(1, 3'd0, 8'h01, 0, "R3");
    send(1, 3'd3, 8'hC0, 0, "R3");
    send(1, 3'd6, 8'h00, 0, "R3");
    send(1, 3'd4, 8'hC2, 8'h00, "R3");
    send(1, 3'd1, 8'h01, 0, "R3");
    send(0, 3'd0, 8'h09, 0, "R5");
    send(0, 3'd3, 8'hC2, 0, "R6");
    send(0, 3'd4, 8'hC2, 8'h00, "R6");
    @(negedge clk);
    chk(secured, "R6", "cpu cannot clear security", secured, 1);

    // Whole-device erase
    send(1, 3'd5, 8'h00, 0, "R4");
    n = 0;
    while (busy) begin
      n++;
      chk(!cpu_ready && !dbg_ready, "R4", "ready during erase", cpu_ready, 0);
      @(negedge clk);
    end
    chk(n == ERASE, "R4", "busy length", n, ERASE);
    chk(!secured, "R4", "security cleared", secured, 0);
    send(0, 3'd3, 8'hC0, 0, "R4");
    send(0, 3'd3, 8'hC2, 0, "R4");
    send(1, 3'd1, 8'h00, 0, "R4");

    // Power-on reset clears registers
    send(1, 3'd4, 8'hC0, 8'h3C, "R7");
    @(negedge clk); por_n = 0; m_main = 0; m_sec = 0; m_secured = 0;
    @(negedge clk); por_n = 1;
    send(0, 3'd3, 8'hC0, 0, "R7");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9", "missing outcomes", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule